// File: doc/BRIEF.md
# Complementary Huffman Test Decompressor

This block expands a compressed test stream on chip. The tester sends one bit at a time over a valid/ready input. The block walks a prefix-free code tree to find which stored symbol the bits select. The bit that follows each codeword is a control bit. It decides whether the symbol's fixed-length block goes out as stored or bitwise inverted. The chosen block is then loaded in parallel into a shift register and sent to a scan chain, one bit per clock.

A single tree leaf serves two blocks that are bitwise complements of each other, so the identification logic stays small. The code is a comma code. A symbol of index k is written as k ones followed by a zero. The symbol table is fixed at elaboration. A run of ones that reaches the tree's unused leaf marks the stream as corrupt.

The decoder is serial. While a block is shifting out, `in_ready` is held low and the tester waits; no bit is dropped. The scan side has no back-pressure: the chain takes one bit on every cycle that `scan_valid` is high. A bit is consumed only in a cycle where both `in_valid` and `in_ready` are high.

Top module: `cmp_huff_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the tree to the root and empties the shift register. After reset, `scan_valid` is 0, `in_ready` is 1 and `err_flag` is 0.
- R2: With the default table, codeword `0` selects block 4'b1101, codeword `10` selects 4'b1011 and codeword `110` selects 4'b0101. In general, symbol k is k ones followed by one zero.
- R3: The stream bit that follows every codeword is a control bit. A value of 0 emits the stored block unchanged. A value of 1 emits its bitwise complement.
- R4: After the control bit is accepted, `scan_valid` is high for exactly 4 consecutive cycles, starting in the next cycle. The block goes out most significant bit first, on `scan_out`.
- R5: `in_ready` is low exactly while `scan_valid` is high. Bits offered with `in_valid` high during that time are not consumed.
- R6: A cycle with `in_valid` low leaves the decode position unchanged, including partway through a codeword.
- R7: Three consecutive ones from the root reach the unused leaf. This sets `err_flag` and returns the tree to the root, and the next bits decode as a fresh codeword. `err_flag` stays set until reset.
- R8: A reset asserted while a block is shifting out abandons the rest of that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip test clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Compressed stream bit |
| in_valid | input | 1 | `in_bit` holds a stream bit |
| in_ready | output | 1 | Decoder can take a stream bit |
| scan_out | output | 1 | Serial decoded data to the scan chain |
| scan_valid | output | 1 | `scan_out` holds a decoded bit |
| err_flag | output | 1 | Sticky flag for an unused codeword |

## Verification
The hardest case to reach from the ports is showing that bits offered during a shift are really ignored. The output looks the same whether or not they were consumed, until the next codeword decodes. So the stimulus keeps `in_valid` high with a one on `in_bit` for the whole output burst, and then sends the shortest codeword. If any stray one had been taken, the tree would sit one level deeper and a different block would come out. In the same way, the stall and error-recovery scenarios are checked through the block that is decoded afterward.

// File: rtl/cmp_huff_pkg.sv
package cmp_huff_pkg;
  // Code-identification phases
  typedef enum logic {
    PH_TREE = 1'b0,   // walking the code tree
    PH_CTRL = 1'b1    // leaf reached, waiting for the invert bit
  } id_phase_e;

  // Default block width and leaf contents (symbol 0 in the low bits)
  localparam int unsigned DEF_BLK_W   = 4;
  localparam int unsigned DEF_NUM_SYM = 3;
  localparam logic [DEF_NUM_SYM*DEF_BLK_W-1:0] DEF_TABLE = {4'b0101, 4'b1011, 4'b1101};
endpackage

// File: rtl/cmp_huff_tree.sv
module cmp_huff_tree
  import cmp_huff_pkg::*;
#(
  parameter int unsigned BLK_W   = DEF_BLK_W,
  parameter int unsigned NUM_SYM = DEF_NUM_SYM,
  parameter logic [NUM_SYM*BLK_W-1:0] SYM_TABLE = DEF_TABLE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic             fire_i,
  output logic             load_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             err_o
);
  localparam int unsigned SYM_W   = (NUM_SYM > 1) ? $clog2(NUM_SYM) : 1;
  localparam int unsigned DEPTH_W = $clog2(NUM_SYM + 1);
  localparam int unsigned LEAF_N  = 1 << SYM_W;
  localparam logic [DEPTH_W-1:0] LAST_DEPTH = DEPTH_W'(NUM_SYM - 1);

  id_phase_e          phase_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [SYM_W-1:0]   sym_q;
  logic               err_q;
  logic [BLK_W-1:0]   leaf_blk [LEAF_N];

  // Unpack the leaf table; unused indices hold zero
  for (genvar g = 0; g < LEAF_N; g++) begin : g_leaf
    if (g < NUM_SYM) begin : g_used
      assign leaf_blk[g] = SYM_TABLE[g*BLK_W +: BLK_W];
    end else begin : g_unused
      assign leaf_blk[g] = '0;
    end
  end

  assign load_o = fire_i && (phase_q == PH_CTRL);
  assign blk_o  = bit_i ? ~leaf_blk[sym_q] : leaf_blk[sym_q];
  assign err_o  = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_TREE;
      depth_q <= '0;
      sym_q   <= '0;
      err_q   <= 1'b0;
    end else if (fire_i) begin
      if (phase_q == PH_CTRL) begin
        phase_q <= PH_TREE;
        depth_q <= '0;
      end else if (!bit_i) begin
        sym_q   <= SYM_W'(depth_q);
        phase_q <= PH_CTRL;
      end else if (depth_q == LAST_DEPTH) begin
        err_q   <= 1'b1;
        depth_q <= '0;
      end else begin
        depth_q <= depth_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_huff_shifter.sv
module cmp_huff_shifter #(
  parameter int unsigned BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [BLK_W-1:0] data_i,
  output logic             ser_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = $clog2(BLK_W + 1);

  logic [BLK_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign ser_o  = sh_q[BLK_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= CNT_W'(BLK_W);
    end else if (busy_o) begin
      sh_q  <= {sh_q[BLK_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cmp_huff_decoder.sv
module cmp_huff_decoder
  import cmp_huff_pkg::*;
#(
  parameter int unsigned BLK_W   = DEF_BLK_W,
  parameter int unsigned NUM_SYM = DEF_NUM_SYM,
  parameter logic [NUM_SYM*BLK_W-1:0] SYM_TABLE = DEF_TABLE
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  output logic scan_out,
  output logic scan_valid,
  output logic err_flag
);
  logic             fire;
  logic             load;
  logic [BLK_W-1:0] blk;
  logic             busy;

  assign in_ready   = !busy;
  assign fire       = in_valid && in_ready;
  assign scan_valid = busy;

  cmp_huff_tree #(
    .BLK_W(BLK_W), .NUM_SYM(NUM_SYM), .SYM_TABLE(SYM_TABLE)
  ) tree_i (
    .clk(clk), .rst(rst), .bit_i(in_bit), .fire_i(fire),
    .load_o(load), .blk_o(blk), .err_o(err_flag)
  );

  cmp_huff_shifter #(.BLK_W(BLK_W)) shift_i (
    .clk(clk), .rst(rst), .load_i(load), .data_i(blk),
    .ser_o(scan_out), .busy_o(busy)
  );
endmodule

// File: rtl/cmp_huff_checker.sv
module cmp_huff_checker #(
  parameter int unsigned BLK_W = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic scan_valid,
  input logic err_flag
);
  localparam int unsigned RUN_W = $clog2(BLK_W + 2) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)             run_q <= '0;
    else if (scan_valid) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!scan_valid && in_ready && !err_flag)); // R1
  AST_LOAD_AFTER_CTRL: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_valid) |-> $past(in_valid && in_ready)); // R3
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(scan_valid) && !$past(rst)) |-> (run_q == RUN_W'(BLK_W))); // R4
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(BLK_W)); // R4
  AST_NO_READY_SHIFT: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> !in_ready); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R7
endmodule

bind cmp_huff_decoder cmp_huff_checker #(.BLK_W(BLK_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .scan_valid(scan_valid), .err_flag(err_flag)
);

// File: tb/cmp_huff_decoder_tb.sv
module cmp_huff_decoder_tb_top;
  logic clk = 1'b0;
  logic rst, in_bit, in_valid;
  logic in_ready, scan_out, scan_valid, err_flag;
  int   checks = 0;
  int   fails  = 0;

  always #10 clk = ~clk;

  cmp_huff_decoder dut_i (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .in_ready(in_ready), .scan_out(scan_out), .scan_valid(scan_valid),
    .err_flag(err_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] table_blk(input int k);
    case (k)
      0: return 4'b1101;
      1: return 4'b1011;
      default: return 4'b0101;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge after the bit is taken
  task automatic send_bit(input logic b);
    in_bit = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Collect the 4-bit burst; optionally offer ones throughout it
  task automatic grab(input string req, input logic [3:0] exp, input logic hold);
    logic [3:0] got = '0;
    if (hold) begin in_valid = 1'b1; in_bit = 1'b1; end
    for (int i = 0; i < 4; i++) begin
      check({req, " R4 valid"}, {7'd0, scan_valid}, 8'd1);
      check({req, " R5 ready"}, {7'd0, in_ready}, 8'd0);
      got = {got[2:0], scan_out};
      @(negedge clk);
    end
    in_valid = 1'b0;
    check({req, " block"}, {4'd0, got}, {4'd0, exp});
    check({req, " R4 end"}, {6'd0, scan_valid, in_ready}, 8'd1);
  endtask

  task automatic send_sym(input int k, input logic w, input logic hold);
    for (int i = 0; i < k; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(w);
    grab(w ? "R3 inv" : "R2 sym", w ? ~table_blk(k) : table_blk(k), hold);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 scan_valid", {7'd0, scan_valid}, 8'd0);
    check("R1 in_ready", {7'd0, in_ready}, 8'd1);
    check("R1 err_flag", {7'd0, err_flag}, 8'd0);
  endtask

  task automatic t_all_symbols();
    for (int k = 0; k < 3; k++) begin
      send_sym(k, 1'b0, 1'b0);
      send_sym(k, 1'b1, 1'b0);
    end
  endtask

  task automatic t_backpressure();
    send_sym(2, 1'b1, 1'b1);
    send_sym(0, 1'b0, 1'b0);  // R5: stray ones would have shifted the tree
  endtask

  task automatic t_stall();
    send_bit(1'b1);
    repeat (5) @(negedge clk);
    check("R6 idle ready", {7'd0, in_ready}, 8'd1);
    send_bit(1'b0);
    repeat (3) @(negedge clk);
    send_bit(1'b1);
    grab("R6 stalled", ~table_blk(1), 1'b0);
  endtask

  task automatic t_error();
    send_bit(1'b1); send_bit(1'b1);
    check("R7 before", {7'd0, err_flag}, 8'd0);
    send_bit(1'b1);
    check("R7 set", {7'd0, err_flag}, 8'd1);
    send_sym(1, 1'b0, 1'b0);
    check("R7 sticky", {7'd0, err_flag}, 8'd1);
    do_reset();
    check("R7 cleared", {7'd0, err_flag}, 8'd0);
  endtask

  task automatic t_reset_mid();
    send_bit(1'b0); send_bit(1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 valid", {7'd0, scan_valid}, 8'd0);
    check("R8 ready", {7'd0, in_ready}, 8'd1);
    send_sym(2, 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    t_reset();
    t_all_symbols();
    t_backpressure();
    t_stall();
    t_error();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule